// File: doc/BRIEF.md
# Partitioned SIMD Lane ALU

This block is a 128-bit integer vector ALU for a wide register datapath. It treats its two source operands as a set of equal-width lanes, with byte, halfword, word or doubleword lanes picked per operation. Within every lane it can add or subtract with wrap-around, with signed saturation, or with unsigned saturation. It can also compare lanes into all-ones/all-zeros masks or apply a bitwise function to the whole operand. Carries and borrows stay inside their lane, so one adder structure serves every partitioning.

An issue stage presents an opcode, a lane-size code, a destination register index and both operands with a valid strobe. One clock later the block returns the result, the destination index and a write enable for the register file. The write enable stays low when the destination index is zero or the opcode is not defined, so the architectural zero register is never written.

Top module: `simd_lane_alu`

## Requirements
- R1: The lane-size code selects the lane width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. Opcode 0 adds and opcode 1 subtracts (src_a minus src_b) modulo the lane width. No carry or borrow passes between adjacent lanes.
- R2: Opcodes 2 (add) and 3 (subtract) saturate as signed values on 8, 16 and 32-bit lanes. A positive overflow gives the lane's largest positive value. A negative overflow gives its most negative value. A result without overflow is exact.
- R3: Opcodes 4 (add) and 5 (subtract) saturate as unsigned values on 8, 16 and 32-bit lanes. An add that carries out gives all ones. A subtract that borrows gives zero.
- R4: On 64-bit lanes the saturating opcodes 2 to 5 wrap like opcodes 0 and 1.
- R5: Opcode 10 sets each result lane to all ones when the two source lanes are equal, and to all zeros otherwise.
- R6: Opcode 11 sets a result lane to all ones only when the src_a lane is strictly greater than the src_b lane, with both read as signed. Equal lanes give zeros.
- R7: Opcodes 6 (AND), 7 (OR), 8 (XOR) and 9 (NOR) act on all 128 bits, whatever the lane-size code.
- R8: A result, its destination index and wr_en appear on the cycle after the clock edge that samples in_valid high. wr_en is low in the cycle after an edge that samples in_valid low.
- R9: A request whose destination index is 0 leaves wr_en low.
- R10: A request with an opcode from 12 to 15 leaves wr_en low.
- R11: While reset is active, and after it is released, wr_en, wr_idx and wr_data are zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| lane_sz | input | 2 | Lane width code |
| dst | input | 5 | Destination register index |
| src_a | input | 128 | First operand |
| src_b | input | 128 | Second operand |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Registered destination index |
| wr_data | output | 128 | Registered result |

## Verification
Every result, the destination index and the write enable pass through exactly one register. They are therefore due one rising edge after the edge that samples the request. The bench drives each request on a falling edge and removes it at the next falling edge, after the capturing rising edge has passed. It samples the outputs at that same falling edge, half a period clear of any edge. For suppressed writes, the bench checks that wr_en is low at that same sampling point.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

   localparam int OP_W = 4;
   localparam int SZ_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_ADDS = 4'd2,
      OP_SUBS = 4'd3,
      OP_ADDU = 4'd4,
      OP_SUBU = 4'd5,
      OP_AND  = 4'd6,
      OP_OR   = 4'd7,
      OP_XOR  = 4'd8,
      OP_NOR  = 4'd9,
      OP_CEQ  = 4'd10,
      OP_CGT  = 4'd11
   } simd_op_e;

   localparam logic [OP_W-1:0] OP_LAST = 4'd11;

   function automatic logic op_is_bitwise(input logic [OP_W-1:0] o);
      return (o >= OP_AND) && (o <= OP_NOR);
   endfunction

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
   import simd_lane_pkg::*;
#(
   parameter int W      = 8,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   output logic [W-1:0]    r
);

   logic [W-1:0] wrap_add, wrap_sub;
   logic [W-1:0] sadd, ssub, uadd, usub;
   logic         eq, gt;

   assign eq = (a == b);
   assign gt = ($signed(a) > $signed(b));

   if (SAT_EN) begin : g_sat
      logic [W:0]   sum, dif;
      logic         ovf_add, ovf_sub;
      logic [W-1:0] clamp;
      assign sum      = {1'b0, a} + {1'b0, b};
      assign dif      = {1'b0, a} - {1'b0, b};
      assign wrap_add = sum[W-1:0];
      assign wrap_sub = dif[W-1:0];
      assign ovf_add  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      assign ovf_sub  = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
      assign clamp    = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      assign sadd     = ovf_add ? clamp : wrap_add;
      assign ssub     = ovf_sub ? clamp : wrap_sub;
      assign uadd     = sum[W] ? {W{1'b1}} : wrap_add;
      assign usub     = dif[W] ? {W{1'b0}} : wrap_sub;
   end else begin : g_wrap
      assign wrap_add = a + b;
      assign wrap_sub = a - b;
      assign sadd     = wrap_add;
      assign ssub     = wrap_sub;
      assign uadd     = wrap_add;
      assign usub     = wrap_sub;
   end

   always_comb begin
      unique case (op)
         OP_ADD:  r = wrap_add;
         OP_SUB:  r = wrap_sub;
         OP_ADDS: r = sadd;
         OP_SUBS: r = ssub;
         OP_ADDU: r = uadd;
         OP_SUBU: r = usub;
         OP_CEQ:  r = {W{eq}};
         OP_CGT:  r = {W{gt}};
         default: r = '0;
      endcase
   end

endmodule

// File: rtl/simd_bitwise.sv
module simd_bitwise
   import simd_lane_pkg::*;
#(
   parameter int W = 128
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   output logic [W-1:0]    r
);

   always_comb begin
      unique case (op)
         OP_AND:  r = a & b;
         OP_OR:   r = a | b;
         OP_XOR:  r = a ^ b;
         OP_NOR:  r = ~(a | b);
         default: r = '0;
      endcase
   end

endmodule

// File: rtl/simd_out_stage.sv
module simd_out_stage #(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              we_in,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              we,
   output logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we   <= 1'b0;
         idx  <= '0;
         data <= '0;
      end else begin
         we <= load & we_in;
         if (load) begin
            idx  <= idx_in;
            data <= data_in;
         end
      end
   end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
   import simd_lane_pkg::*;
#(
   parameter int DATA_W     = 128,
   parameter int IDX_W      = 5,
   parameter int MIN_LANE_W = 8,
   parameter int SAT_MAX_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [1:0]        lane_sz,
   input  logic [IDX_W-1:0]  dst,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data
);

   localparam int NUM_SIZES = 1 << SZ_W;
   localparam int MAX_LANE  = MIN_LANE_W << (NUM_SIZES - 1);

   if (DATA_W % MAX_LANE != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of the widest lane");
   end
   if (SAT_MAX_W > MAX_LANE || SAT_MAX_W < MIN_LANE_W) begin : g_bad_sat
      $error("SAT_MAX_W must lie within the supported lane widths");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end

   logic [NUM_SIZES-1:0][DATA_W-1:0] lane_res;
   logic [DATA_W-1:0]                bit_res;
   logic [DATA_W-1:0]                result;
   logic                             op_ok;
   logic                             do_write;

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int LW = MIN_LANE_W << g;
      localparam int NL = DATA_W / LW;
      for (genvar l = 0; l < NL; l++) begin : g_lane
         simd_lane_unit #(
            .W      (LW),
            .SAT_EN (LW <= SAT_MAX_W)
         ) u_lane (
            .op (op),
            .a  (src_a[l*LW +: LW]),
            .b  (src_b[l*LW +: LW]),
            .r  (lane_res[g][l*LW +: LW])
         );
      end
   end

   simd_bitwise #(
      .W (DATA_W)
   ) u_bitwise (
      .op (op),
      .a  (src_a),
      .b  (src_b),
      .r  (bit_res)
   );

   assign result   = op_is_bitwise(op) ? bit_res : lane_res[lane_sz];
   assign op_ok    = (op <= OP_LAST);
   assign do_write = op_ok && (dst != '0);

   simd_out_stage #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (in_valid),
      .we_in   (do_write),
      .idx_in  (dst),
      .data_in (result),
      .we      (wr_en),
      .idx     (wr_idx),
      .data    (wr_data)
   );

endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk
   import simd_lane_pkg::*;
#(
   parameter int DATA_W = 128,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op,
   input logic [1:0]        lane_sz,
   input logic [IDX_W-1:0]  dst,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data
);

   AST_ZERO_DST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst == '0) |=> !wr_en); // R9

   AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op > OP_LAST) |=> !wr_en); // R10

   AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst != '0 && op <= OP_LAST) |=> (wr_en && wr_idx == $past(dst))); // R8

   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !wr_en); // R8

   AST_AND_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dst != '0 && op == OP_AND) |=> (wr_data == $past(src_a & src_b))); // R7

   for (genvar i = 0; i < DATA_W / 8; i++) begin : g_mask
      AST_EQ_MASK_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dst != '0 && op == OP_CEQ && lane_sz == 2'd0)
         |=> (wr_data[i*8 +: 8] == 8'h00 || wr_data[i*8 +: 8] == 8'hFF)); // R5
   end

endmodule

bind simd_lane_alu simd_lane_alu_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .op       (op),
   .lane_sz  (lane_sz),
   .dst      (dst),
   .src_a    (src_a),
   .src_b    (src_b),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_data  (wr_data)
);

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;

   typedef struct packed {
      logic [3:0]   req;
      logic [3:0]   op;
      logic [1:0]   sz;
      logic [127:0] a;
      logic [127:0] b;
      logic [127:0] x;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{4'd1, 4'd0,  2'd0, {16{8'hFF}}, {16{8'h01}}, {16{8'h00}}},                               // R1 byte wrap
      '{4'd1, 4'd0,  2'd1, {8{16'h00FF}}, {8{16'h0001}}, {8{16'h0100}}},                         // R1 half carry inside lane
      '{4'd1, 4'd1,  2'd2, {4{32'h0}}, {4{32'h1}}, {4{32'hFFFFFFFF}}},                           // R1 word borrow
      '{4'd1, 4'd0,  2'd3, {2{64'h00000000FFFFFFFF}}, {2{64'h1}}, {2{64'h0000000100000000}}},    // R1 dword
      '{4'd2, 4'd2,  2'd0, {16{8'h70}}, {16{8'h20}}, {16{8'h7F}}},                               // R2 positive clamp
      '{4'd2, 4'd3,  2'd1, {8{16'h8000}}, {8{16'h0001}}, {8{16'h8000}}},                         // R2 negative clamp
      '{4'd2, 4'd2,  2'd2, {4{32'h5}}, {4{32'hFFFFFFFD}}, {4{32'h2}}},                           // R2 exact
      '{4'd3, 4'd4,  2'd0, {16{8'hF0}}, {16{8'h20}}, {16{8'hFF}}},                               // R3 add clamp
      '{4'd3, 4'd5,  2'd2, {4{32'h5}}, {4{32'h6}}, {4{32'h0}}},                                  // R3 sub clamp
      '{4'd3, 4'd4,  2'd1, {8{16'h1000}}, {8{16'h0234}}, {8{16'h1234}}},                         // R3 exact
      '{4'd4, 4'd2,  2'd3, {2{64'h7FFFFFFFFFFFFFFF}}, {2{64'h1}}, {2{64'h8000000000000000}}},    // R4 dword wraps
      '{4'd5, 4'd10, 2'd1, {4{32'h12345678}}, {4{32'h12340000}}, {4{32'hFFFF0000}}},             // R5 equal mask
      '{4'd6, 4'd11, 2'd0, {8{16'h0180}}, {8{16'h8001}}, {8{16'hFF00}}},                         // R6 signed gt
      '{4'd6, 4'd11, 2'd2, {4{32'h5}}, {4{32'h5}}, {4{32'h0}}},                                  // R6 strict
      '{4'd7, 4'd6,  2'd0, {2{64'h0F0FFF001234ABCD}}, {2{64'hFFFF0F0F00FFF0F0}}, {2{64'h0F0F0F000034A0C0}}}, // R7 AND
      '{4'd7, 4'd9,  2'd3, {4{32'hF0F0F0F0}}, {4{32'h0F0F0000}}, {4{32'h00000F0F}}},             // R7 NOR
      '{4'd7, 4'd8,  2'd1, {8{16'hAAAA}}, {8{16'h5555}}, {8{16'hFFFF}}},                         // R7 XOR
      '{4'd7, 4'd7,  2'd2, {4{32'h1}}, {4{32'h100}}, {4{32'h101}}}                               // R7 OR
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op = '0;
   logic [1:0]   lane_sz = '0;
   logic [4:0]   dst = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         wr_en;
   logic [4:0]   wr_idx;
   logic [127:0] wr_data;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   simd_lane_alu u_simd_lane_alu (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .op       (op),
      .lane_sz  (lane_sz),
      .dst      (dst),
      .src_a    (src_a),
      .src_b    (src_b),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] o, input logic [1:0] s, input logic [4:0] d,
                        input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      in_valid = 1'b1; op = o; lane_sz = s; dst = d; src_a = a; src_b = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset wr_en", {127'd0, wr_en}, '0);
      check("R11 reset wr_data", wr_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 post-reset wr_en", {127'd0, wr_en}, '0);
      check("R11 post-reset wr_idx", {123'd0, wr_idx}, '0);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].op, VECS[i].sz, 5'd3, VECS[i].a, VECS[i].b);
         check($sformatf("R%0d vector %0d data", VECS[i].req, i), wr_data, VECS[i].x);
         check($sformatf("R8 vector %0d wr_en", i), {127'd0, wr_en}, 128'd1);
      end

      // R8: enable drops one cycle after the request is withdrawn
      @(negedge clk);
      check("R8 idle wr_en", {127'd0, wr_en}, '0);

      // R8: destination index follows the request
      issue(4'd0, 2'd0, 5'd17, '0, '0);
      check("R8 wr_idx", {123'd0, wr_idx}, 128'd17);

      // R9: destination 0 gives no write
      issue(4'd0, 2'd0, 5'd0, {16{8'h11}}, {16{8'h22}});
      check("R9 zero dst wr_en", {127'd0, wr_en}, '0);

      // R10: undefined opcodes give no write
      issue(4'd12, 2'd0, 5'd5, '1, '1);
      check("R10 op 12 wr_en", {127'd0, wr_en}, '0);
      issue(4'd15, 2'd3, 5'd6, '1, '1);
      check("R10 op 15 wr_en", {127'd0, wr_en}, '0);

      // R2: mixed lanes, only the overflowing lane clamps
      issue(4'd2, 2'd0, 5'd2, {{15{8'h01}}, 8'h90}, {{15{8'h02}}, 8'h90});
      check("R2 mixed lanes", wr_data, {{15{8'h03}}, 8'h80});

      // R1: byte subtraction borrow confined
      issue(4'd1, 2'd0, 5'd2, {8{16'h0100}}, {8{16'h0001}});
      check("R1 byte borrow confined", wr_data, {8{16'h01FF}});

      // R4: unsigned saturating subtract on dword lanes wraps
      issue(4'd5, 2'd3, 5'd2, '0, {2{64'h1}});
      check("R4 dword usub wraps", wr_data, '1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule